// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to 63 level-sensitive interrupt request lines and presents a single winner to a processor. Request lines are numbered 1 to 63. Line 0 is reserved: it never raises an interrupt and has no configuration. Each source has a small control register that assigns it an interrupt level from 0 to 7 and a tie-break priority within that level. A 64-bit block mask, split into a low word and a high word, lets software silence single sources. Bit 0 of the low word does not belong to a source. It is a global switch that blocks everything.

Software reaches the mask words and the control registers through a plain register bus. There is a write strobe, a 7-bit byte address, a 32-bit write word, and read data that follows the address combinationally. The two mask words sit at addresses 0x00 (low) and 0x01 (high). The control register of source n sits at 0x40 + n. Every other address reads zero and ignores writes.

The processor sees a registered 3-bit level and a 6-bit vector number, which is the index of the winning source. When nothing qualifies, both outputs are zero.

Top module: `prio_intc`

## Requirements
- R1: After reset, both mask words read 0xFFFFFFFF, every control register reads 0x00, and the level and vector outputs are 0.
- R2: Source n is blocked by mask bit n[4:0] of the high word when n[5] is 1, and of the low word when n[5] is 0. A 1 blocks the source and a 0 passes it.
- R3: While bit 0 of the low mask word is 1, the level output stays 0 whatever the other mask bits hold. Writing 0x00000001 to the low word therefore blocks every source.
- R4: A control register keeps write bits 5:3 as its level and bits 2:0 as its priority. Bits 7:6 read back as 0.
- R5: A source whose level field is 0 never produces a nonzero level output, even when it is requesting and unmasked.
- R6: Among eligible sources (requesting, unmasked, nonzero level), the one with the highest level wins.
- R7: Among eligible sources of equal level, the one with the higher priority field wins.
- R8: Among eligible sources with equal level and equal priority, the lower source index wins.
- R9: The vector output equals the winner's index and the level output equals the winner's level. When there is no eligible source, both outputs are 0.
- R10: The outputs are registered. They change on the first rising clock edge after a change of request, mask or control, and not before it.
- R11: Slot 0 is reserved. Its control register reads 0 and ignores writes, and request line 0 never produces an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| irq_req | input | 64 | Level request lines; bit n is source n, bit 0 unused |
| cpu_level | output | 3 | Level of the current winner, 0 when idle |
| cpu_vector | output | 6 | Index of the current winner, 0 when idle |

## Verification
A register write takes effect at the rising edge during its strobe. The level and vector outputs reflect that write one edge later. A change on the request lines reaches the outputs at the first edge after it. Read data is valid in the same cycle as the address. The bench changes inputs on falling edges. It samples reads 1 ns after setting the address, and it samples the outputs at the falling edge after the edge that updates them. For the timing requirement it also samples just before that edge, to confirm the old value still holds.

// File: rtl/prio_intc_pkg.sv
// Package: shared sizes and the per-source control record of the
// prioritised interrupt controller. Assumes a power-of-two source count.
package prio_intc_pkg;
    parameter int NSRC   = 64;
    parameter int IDX_W  = $clog2(NSRC);
    parameter int LVL_W  = 3;
    parameter int PRI_W  = 3;
    parameter int WORD_W = 32;
    parameter int ADDR_W = 7;

    // Level above priority, so a packed compare ranks level first.
    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [PRI_W-1:0] pri;
    } src_ctl_t;
endpackage

// File: rtl/intc_regs.sv
// Module: register file of the controller. It holds the two mask words
// and one control record per source, and decodes bus writes and reads.
// Assumes NSRC == 2*WORD_W and that slot 0 has no storage.
module intc_regs
    import prio_intc_pkg::*;
#(
    parameter int N     = NSRC,
    parameter int W     = WORD_W,
    parameter int AW    = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [W-1:0]         bus_wdata,
    output logic [W-1:0]         bus_rdata,
    output logic [N-1:0]         mask_vec,
    output src_ctl_t [N-1:0]     ctl_vec
);
    localparam int IW        = $clog2(N);
    localparam int CTL_W     = $bits(src_ctl_t);
    localparam logic [AW-1:0] ADDR_MLO = '0;
    localparam logic [AW-1:0] ADDR_MHI = AW'(1);

    logic         ctl_sel;
    logic [IW-1:0] ctl_idx;
    logic [W-1:0] mask_lo_q, mask_hi_q;

    assign ctl_sel = bus_addr[AW-1];
    assign ctl_idx = bus_addr[IW-1:0];

    // Mask words: all blocked after reset, word-wide writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_lo_q <= '1;
            mask_hi_q <= '1;
        end else if (bus_wr && bus_addr == ADDR_MLO) begin
            mask_lo_q <= bus_wdata;
        end else if (bus_wr && bus_addr == ADDR_MHI) begin
            mask_hi_q <= bus_wdata;
        end
    end

    assign mask_vec = {mask_hi_q, mask_lo_q};

    // Slot 0 is reserved and has no storage.
    assign ctl_vec[0] = '0;

    // One control record per source 1..N-1.
    for (genvar g = 1; g < N; g++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctl_vec[g] <= '0;
            else if (bus_wr && ctl_sel && ctl_idx == IW'(g))
                ctl_vec[g] <= src_ctl_t'(bus_wdata[CTL_W-1:0]);
        end
    end

    // Read mux: mask words, control records, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (ctl_sel)
            bus_rdata = W'(ctl_vec[ctl_idx]);
        else if (bus_addr == ADDR_MLO)
            bus_rdata = mask_lo_q;
        else if (bus_addr == ADDR_MHI)
            bus_rdata = mask_hi_q;
    end
endmodule

// File: rtl/intc_pick.sv
// Module: combinational arbiter. It finds the eligible source with the
// largest {level, priority} key, with ties going to the lower index.
// Assumes bit 0 of the mask is the global mask-all.
module intc_pick
    import prio_intc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]        req,
    input  logic [N-1:0]        mask,
    input  src_ctl_t [N-1:0]    ctl,
    output logic [LVL_W-1:0]    win_lvl,
    output logic [$clog2(N)-1:0] win_idx
);
    localparam int IW = $clog2(N);

    logic [N-1:0] elig;

    // A source is eligible when it requests, is unmasked, has nonzero level.
    assign elig[0] = 1'b0;
    for (genvar g = 1; g < N; g++) begin : g_elig
        assign elig[g] = req[g] && !mask[g] && !mask[0] && (ctl[g].lvl != '0);
    end

    // Descending scan with >= so that equal keys settle on the lower index.
    always_comb begin
        src_ctl_t best;
        best    = '0;
        win_idx = '0;
        for (int i = N - 1; i >= 1; i--) begin
            if (elig[i] && ctl[i] >= best) begin
                best    = ctl[i];
                win_idx = IW'(i);
            end
        end
        win_lvl = best.lvl;
    end
endmodule

// File: rtl/prio_intc.sv
// Module: top of the prioritised vectored interrupt controller. It ties
// the register file to the arbiter and registers the winner toward the CPU.
// Assumes level-sensitive requests that are already synchronous to clk.
module prio_intc
    import prio_intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   irq_req,
    output logic [LVL_W-1:0]  cpu_level,
    output logic [IDX_W-1:0]  cpu_vector
);
    logic [NSRC-1:0]      mask_vec;
    src_ctl_t [NSRC-1:0]  ctl_vec;
    logic [LVL_W-1:0]     win_lvl;
    logic [IDX_W-1:0]     win_idx;

    intc_regs #(.N(NSRC), .W(WORD_W), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mask_vec  (mask_vec),
        .ctl_vec   (ctl_vec)
    );

    intc_pick #(.N(NSRC)) u_pick (
        .req     (irq_req),
        .mask    (mask_vec),
        .ctl     (ctl_vec),
        .win_lvl (win_lvl),
        .win_idx (win_idx)
    );

    // Output register: the winner is presented one edge after any change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_level  <= '0;
            cpu_vector <= '0;
        end else begin
            cpu_level  <= win_lvl;
            cpu_vector <= win_idx;
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
// Module: assertion checker for prio_intc, bound to the top. It keeps its
// own one-cycle copies of requests and mask to judge the registered winner.
module prio_intc_chk
    import prio_intc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   irq_req,
    input logic [NSRC-1:0]   mask_vec,
    input logic [LVL_W-1:0]  cpu_level,
    input logic [IDX_W-1:0]  cpu_vector
);
    logic [NSRC-1:0] req_d, mask_d;

    // Delay copies matching the output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d  <= '0;
            mask_d <= '1;
        end else begin
            req_d  <= irq_req;
            mask_d <= mask_vec;
        end
    end

    assert_mask_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mask_vec[0] |=> cpu_level == '0);

    assert_idle_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_level == '0 |-> cpu_vector == '0);

    assert_no_slot0_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_level != '0 |-> cpu_vector != '0);

    assert_winner_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_level != '0 |-> (req_d[cpu_vector] && !mask_d[cpu_vector]));
endmodule

bind prio_intc prio_intc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .mask_vec   (mask_vec),
    .cpu_level  (cpu_level),
    .cpu_vector (cpu_vector)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_req = '0;
    logic [2:0]  cpu_level;
    logic [5:0]  cpu_vector;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_intc u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .cpu_level(cpu_level), .cpu_vector(cpu_vector)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(string tag, logic [6:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic out(string tag, logic [2:0] lvl, logic [5:0] vec);
        check({tag, " level"}, 32'(cpu_level), 32'(lvl));
        check({tag, " vector"}, 32'(cpu_vector), 32'(vec));
    endtask

    // R1: reset values.
    task automatic t_reset();
        rd("R1 mask low", 7'h00, 32'hFFFF_FFFF);
        rd("R1 mask high", 7'h01, 32'hFFFF_FFFF);
        rd("R1 ctl 5", 7'h45, 32'h0);
        out("R1 outputs", 3'd0, 6'd0);
    endtask

    // R4: control field layout.
    task automatic t_ctrl();
        wr(7'h45, 32'h1A);
        rd("R4 ctl 5", 7'h45, 32'h1A);
        wr(7'h49, 32'hFF);
        rd("R4 upper bits zero", 7'h49, 32'h3F);
        wr(7'h49, 32'h0);
    endtask

    // R9, R10: routing and one-edge latency.
    task automatic t_route();
        wr(7'h00, 32'h0);
        wr(7'h01, 32'h0);
        step();
        irq_req = 64'h1 << 5;
        #1 out("R10 before edge", 3'd0, 6'd0);
        step();
        out("R9 single source", 3'd3, 6'd5);
        irq_req = '0;
        #1 out("R10 hold before edge", 3'd3, 6'd5);
        step();
        out("R9 idle", 3'd0, 6'd0);
    endtask

    // R3: global mask-all.
    task automatic t_maskall();
        irq_req = 64'h1 << 5;
        wr(7'h00, 32'h1);
        step();
        out("R3 mask-all", 3'd0, 6'd0);
        wr(7'h00, 32'h0);
        step();
        out("R3 release", 3'd3, 6'd5);
    endtask

    // R2, R6: per-source mask bits in both words, level ranking.
    task automatic t_mask();
        wr(7'h00, 32'h20);
        step();
        out("R2 low word bit5", 3'd0, 6'd0);
        wr(7'h00, 32'h0);
        wr(7'h65, 32'h21);
        wr(7'h01, 32'h20);
        irq_req = (64'h1 << 5) | (64'h1 << 37);
        step();
        out("R2 high word bit5", 3'd3, 6'd5);
        wr(7'h01, 32'h0);
        step();
        out("R6 higher level", 3'd4, 6'd37);
    endtask

    // R5: level zero never asserts.
    task automatic t_lvl0();
        wr(7'h4A, 32'h07);
        irq_req = 64'h1 << 10;
        step();
        out("R5 level zero", 3'd0, 6'd0);
    endtask

    // R7, R8: priority and index tie-breaks.
    task automatic t_ties();
        wr(7'h54, 32'h1D);
        irq_req = (64'h1 << 5) | (64'h1 << 20);
        step();
        out("R7 priority", 3'd3, 6'd20);
        wr(7'h4C, 32'h1D);
        irq_req = (64'h1 << 12) | (64'h1 << 20);
        step();
        out("R8 lower index", 3'd3, 6'd12);
    endtask

    // R11: reserved slot.
    task automatic t_slot0();
        wr(7'h40, 32'h3F);
        rd("R11 ctl 0", 7'h40, 32'h0);
        irq_req = 64'h1;
        step();
        out("R11 line 0", 3'd0, 6'd0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_ctrl();
        t_route();
        t_maskall();
        t_mask();
        t_lvl0();
        t_ties();
        t_slot0();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule